// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects five hardware interrupt sources and turns them into one request line for a processor core, together with the service address of the winning source. One source is non-maskable and edge-triggered. One is a maskable, edge-triggered request held in a pending latch. Two are maskable level requests. The last is a general level request that has no fixed address, so the interrupting device must supply the routine address itself.

The core controls acceptance through a global enable, which it sets and clears with single-cycle command pulses, and through a three-bit mask written by a mask command. That mask command can also flush the edge latch. When the core takes the interrupt it pulses `ack`. The acknowledge clears the latch of the source that won, if that source has one, and drops the global enable. All pins are plain control and status signals and none carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the global enable is off and all three mask bits are set (blocked). `irq` is low, and level requests do not raise it until the core enables and unmasks them.
- R2: Priority, from highest to lowest, is `urgent_req`, `edge_req`, `lvl_req_hi`, `lvl_req_lo`, `ext_req`. The vectors are 0x0024, 0x003C, 0x0034 and 0x002C for the first four sources. Only the highest eligible source drives `vec_addr`.
- R3: `urgent_req` is served even when the global enable is off and the mask is all ones.
- R4: `urgent_req` raises a request only on a rising edge, and only while the input stays high. An input held high is served once. If the input drops before `ack`, the request is withdrawn.
- R5: A rising edge on `edge_req` is latched, so a one-cycle pulse is remembered. Holding the input high does not re-trigger after the acknowledge. A mask write with `mask_flush`=1 empties the latch.
- R6: Mask bit positions are `mask_din[2]` for `edge_req`, `[1]` for `lvl_req_hi` and `[0]` for `lvl_req_lo`, and 1 blocks the source. A masked `edge_req` edge is still latched and is presented once it is unmasked. `lvl_req_hi`, `lvl_req_lo` and `ext_req` follow the input level.
- R7: `en_clr` blocks every source except `urgent_req`, and `en_set` restores them. An accepted `ack` clears the enable. When `ack` and `en_set` fall in the same cycle, the enable ends up clear.
- R8: When `ext_req` wins, `vec_ext` is 1 and `vec_addr` is 0.
- R9: `ack` clears only the latch of the winning source; other pending latches and levels remain. An `ack` while `irq` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| urgent_req | input | 1 | Non-maskable edge request |
| edge_req | input | 1 | Maskable edge request, latched |
| lvl_req_hi | input | 1 | Maskable level request, higher |
| lvl_req_lo | input | 1 | Maskable level request, lower |
| ext_req | input | 1 | Level request needing an external vector |
| en_set | input | 1 | Set the global enable |
| en_clr | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Load the mask register |
| mask_din | input | 3 | New mask bits |
| mask_flush | input | 1 | With mask_wr, empty the edge latch |
| ack | input | 1 | Core accepts the presented request |
| irq | output | 1 | Interrupt request to the core |
| vec_addr | output | AW | Service address of the winner |
| vec_ext | output | 1 | Winner needs a device-supplied address |

## Verification
The bench builds the block with its default parameters: a 16-bit address and four distinct vector values. Because the vectors differ, a priority inversion or a misrouted table entry shows up as a wrong address rather than passing unnoticed. The defaults also keep the edge latches and the enable state at their real sizes, so the bench can exercise flush, re-trigger, acknowledge-versus-enable collisions and masked-edge retention directly.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NSRC    = 5;
  localparam int IDX_URG = 4;
  localparam int IDX_EDG = 3;
  localparam int IDX_HI  = 2;
  localparam int IDX_LO  = 1;
  localparam int IDX_EXT = 0;
  localparam int MASK_W  = 3;
endpackage

// File: rtl/pirq_edge_latch.sv
module pirq_edge_latch #(
  parameter bit NEED_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise;
  logic drop_clr;

  assign rise = lvl & ~prev_q;

  generate
    if (NEED_LEVEL) begin : g_lvl
      assign drop_clr = ~lvl;
    end else begin : g_nolvl
      assign drop_clr = 1'b0;
    end
  endgenerate

  // previous value resets high: a level already present at reset is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (rise)
        pend <= 1'b1;
      else if (clr || drop_clr)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pirq_enable.sv
module pirq_enable #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          accept,
  input  logic          mask_wr,
  input  logic [MW-1:0] mask_din,
  output logic          gie,
  output logic [MW-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      mask <= '1;
    end else begin
      if (accept || en_clr)
        gie <= 1'b0;
      else if (en_set)
        gie <= 1'b1;
      if (mask_wr)
        mask <= mask_din;
    end
  end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter #(
  parameter int             N         = 5,
  parameter int             AW        = 16,
  parameter int             EXT_IDX   = 0,
  parameter logic [N*AW-1:0] VEC_TABLE = '0
) (
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  win,
  output logic          irq,
  output logic [AW-1:0] vec,
  output logic          ext
);
  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && !found) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
    irq = found;
    vec = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i] && i != EXT_IDX)
        vec = vec | VEC_TABLE[i*AW +: AW];
    end
    ext = win[EXT_IDX];
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [AW-1:0] VEC_URG = 16'h0024,
  parameter logic [AW-1:0] VEC_EDG = 16'h003C,
  parameter logic [AW-1:0] VEC_HI  = 16'h0034,
  parameter logic [AW-1:0] VEC_LO  = 16'h002C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              urgent_req,
  input  logic              edge_req,
  input  logic              lvl_req_hi,
  input  logic              lvl_req_lo,
  input  logic              ext_req,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_din,
  input  logic              mask_flush,
  input  logic              ack,
  output logic              irq,
  output logic [AW-1:0]     vec_addr,
  output logic              vec_ext
);
  localparam logic [NSRC*AW-1:0] TABLE = {VEC_URG, VEC_EDG, VEC_HI, VEC_LO, {AW{1'b0}}};

  logic              gie;
  logic [MASK_W-1:0] mask;
  logic              u_pend;
  logic              a_pend;
  logic [NSRC-1:0]   elig;
  logic [NSRC-1:0]   win;
  logic              accept;

  assign accept = ack & irq;

  pirq_edge_latch #(.NEED_LEVEL(1'b1)) u_urg (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (urgent_req),
    .clr  (accept & win[IDX_URG]),
    .pend (u_pend)
  );

  pirq_edge_latch #(.NEED_LEVEL(1'b0)) u_edg (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (edge_req),
    .clr  ((accept & win[IDX_EDG]) | (mask_wr & mask_flush)),
    .pend (a_pend)
  );

  pirq_enable #(.MW(MASK_W)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .accept  (accept),
    .mask_wr (mask_wr),
    .mask_din(mask_din),
    .gie     (gie),
    .mask    (mask)
  );

  always_comb begin
    elig          = '0;
    elig[IDX_URG] = u_pend & urgent_req;
    elig[IDX_EDG] = a_pend & ~mask[2] & gie;
    elig[IDX_HI]  = lvl_req_hi & ~mask[1] & gie;
    elig[IDX_LO]  = lvl_req_lo & ~mask[0] & gie;
    elig[IDX_EXT] = ext_req & gie;
  end

  pirq_arbiter #(
    .N        (NSRC),
    .AW       (AW),
    .EXT_IDX  (IDX_EXT),
    .VEC_TABLE(TABLE)
  ) u_arb (
    .elig(elig),
    .win (win),
    .irq (irq),
    .vec (vec_addr),
    .ext (vec_ext)
  );
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] VEC_URG = 16'h0024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [AW-1:0] vec_addr,
  input logic          vec_ext,
  input logic          ack,
  input logic          mask_wr,
  input logic          mask_flush,
  input logic          edge_req,
  input logic          gie,
  input logic          a_pend,
  input logic [4:0]    win
);
  assert_extvec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ext |-> (irq && vec_addr == '0));

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !gie) |-> (vec_addr == VEC_URG));

  assert_ackclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> !gie);

  assert_onewin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_flush && !edge_req) |=> !a_pend);

  assert_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && vec_addr == VEC_URG) |=> !(irq && vec_addr == VEC_URG));
endmodule

bind prio_irq_ctrl pirq_chk #(.AW(AW), .VEC_URG(VEC_URG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .vec_addr  (vec_addr),
  .vec_ext   (vec_ext),
  .ack       (ack),
  .mask_wr   (mask_wr),
  .mask_flush(mask_flush),
  .edge_req  (edge_req),
  .gie       (gie),
  .a_pend    (a_pend),
  .win       (win)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        urgent_req = 1'b0, edge_req = 1'b0, lvl_req_hi = 1'b0, lvl_req_lo = 1'b0, ext_req = 1'b0;
  logic        en_set = 1'b0, en_clr = 1'b0, mask_wr = 1'b0, mask_flush = 1'b0, ack = 1'b0;
  logic [2:0]  mask_din = 3'b000;
  logic        irq;
  logic [15:0] vec_addr;
  logic        vec_ext;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam logic [15:0] V_URG = 16'h0024, V_EDG = 16'h003C, V_HI = 16'h0034, V_LO = 16'h002C;

  always #2 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .urgent_req(urgent_req), .edge_req(edge_req),
    .lvl_req_hi(lvl_req_hi), .lvl_req_lo(lvl_req_lo), .ext_req(ext_req),
    .en_set(en_set), .en_clr(en_clr), .mask_wr(mask_wr), .mask_din(mask_din),
    .mask_flush(mask_flush), .ack(ack), .irq(irq), .vec_addr(vec_addr), .vec_ext(vec_ext)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic ei, input logic [15:0] ev, input logic ex);
    n_chk++;
    if (irq !== ei || (ei && (vec_addr !== ev || vec_ext !== ex))) begin
      n_bad++;
      $display("FAIL %s: irq=%0b vec=%h ext=%0b expected irq=%0b vec=%h ext=%0b",
               tag, irq, vec_addr, vec_ext, ei, ev, ex);
    end
  endtask

  task automatic set_en();
    en_set = 1'b1; step(); en_set = 1'b0;
  endtask

  task automatic clr_en();
    en_clr = 1'b1; step(); en_clr = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic write_mask(input logic [2:0] d, input logic f);
    mask_wr = 1'b1; mask_din = d; mask_flush = f; step();
    mask_wr = 1'b0; mask_flush = 1'b0;
  endtask

  task automatic pulse_edge();
    edge_req = 1'b1; step(); edge_req = 1'b0; step();
  endtask

  task automatic t_reset();
    expect_out("R1 idle after reset", 1'b0, 16'h0, 1'b0);
    lvl_req_hi = 1'b1; step();
    expect_out("R1 level blocked after reset", 1'b0, 16'h0, 1'b0);
    lvl_req_hi = 1'b0; step();
  endtask

  task automatic t_levels();
    set_en(); write_mask(3'b000, 1'b0);
    lvl_req_lo = 1'b1; step();
    expect_out("R6 low level", 1'b1, V_LO, 1'b0);
    lvl_req_hi = 1'b1; step();
    expect_out("R2 hi over lo", 1'b1, V_HI, 1'b0);
    write_mask(3'b010, 1'b0);
    expect_out("R6 hi masked", 1'b1, V_LO, 1'b0);
    lvl_req_lo = 1'b0; step();
    expect_out("R6 only masked level", 1'b0, 16'h0, 1'b0);
    write_mask(3'b000, 1'b0);
    lvl_req_hi = 1'b0; ext_req = 1'b1; step();
    expect_out("R8 external vector", 1'b1, 16'h0, 1'b1);
    lvl_req_lo = 1'b1; step();
    expect_out("R2 lo over ext", 1'b1, V_LO, 1'b0);
    do_ack();
    expect_out("R7 ack clears enable", 1'b0, 16'h0, 1'b0);
    set_en();
    expect_out("R9 level stays after ack", 1'b1, V_LO, 1'b0);
    lvl_req_lo = 1'b0; ext_req = 1'b0; step();
  endtask

  task automatic t_edge();
    pulse_edge();
    expect_out("R5 short pulse latched", 1'b1, V_EDG, 1'b0);
    lvl_req_hi = 1'b1; step();
    expect_out("R2 edge over hi", 1'b1, V_EDG, 1'b0);
    do_ack(); set_en();
    expect_out("R9 only winner cleared", 1'b1, V_HI, 1'b0);
    lvl_req_hi = 1'b0;
    edge_req = 1'b1; step();
    expect_out("R5 held input latched", 1'b1, V_EDG, 1'b0);
    do_ack(); set_en();
    expect_out("R5 held input no retrigger", 1'b0, 16'h0, 1'b0);
    edge_req = 1'b0; step();
    write_mask(3'b100, 1'b0);
    pulse_edge();
    expect_out("R6 masked edge hidden", 1'b0, 16'h0, 1'b0);
    write_mask(3'b000, 1'b0);
    expect_out("R6 masked edge kept", 1'b1, V_EDG, 1'b0);
    write_mask(3'b000, 1'b1);
    expect_out("R5 flush empties latch", 1'b0, 16'h0, 1'b0);
    write_mask(3'b100, 1'b0);
    pulse_edge();
    do_ack();
    write_mask(3'b000, 1'b0);
    expect_out("R9 idle ack no effect", 1'b1, V_EDG, 1'b0);
    do_ack();
  endtask

  task automatic t_urgent();
    write_mask(3'b111, 1'b0);
    urgent_req = 1'b1; step();
    expect_out("R3 unmaskable while disabled", 1'b1, V_URG, 1'b0);
    do_ack();
    expect_out("R4 held served once", 1'b0, 16'h0, 1'b0);
    step();
    expect_out("R4 still once", 1'b0, 16'h0, 1'b0);
    urgent_req = 1'b0; step(); urgent_req = 1'b1; step();
    expect_out("R4 new edge", 1'b1, V_URG, 1'b0);
    urgent_req = 1'b0; step();
    expect_out("R4 dropped before ack", 1'b0, 16'h0, 1'b0);
    write_mask(3'b000, 1'b0); set_en();
    pulse_edge();
    urgent_req = 1'b1; step();
    expect_out("R2 urgent over edge", 1'b1, V_URG, 1'b0);
    do_ack();
    expect_out("R7 urgent ack clears enable", 1'b0, 16'h0, 1'b0);
    set_en();
    expect_out("R9 edge kept after urgent ack", 1'b1, V_EDG, 1'b0);
    urgent_req = 1'b0; do_ack();
  endtask

  task automatic t_enable();
    set_en();
    lvl_req_lo = 1'b1; step();
    expect_out("R7 enabled level", 1'b1, V_LO, 1'b0);
    clr_en();
    expect_out("R7 disable blocks", 1'b0, 16'h0, 1'b0);
    set_en();
    expect_out("R7 enable restores", 1'b1, V_LO, 1'b0);
    ack = 1'b1; en_set = 1'b1; step(); ack = 1'b0; en_set = 1'b0;
    expect_out("R7 ack beats set", 1'b0, 16'h0, 1'b0);
    lvl_req_lo = 1'b0; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_levels();
    t_edge();
    t_urgent();
    t_enable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule